// File: doc/BRIEF.md
# Disk sector transfer engine

This block moves 16-bit words between a host data channel and a sector buffer of `WORDS` entries (128 by default). It supports six operations: read, write, check, address skip, read address and write address. The operation, the requested cylinder, head and sector, and a 9-bit sector count for check mode are latched by a one-cycle `start` pulse. From then on the engine runs by itself. It paces its word steps with a programmable interval. At every sector boundary it asks an external media model to load or store the buffer, and it hands each word to or from the channel with a command/flag handshake.

At the start of each sector the engine checks the address it holds. A fault stops the operation, and an error code is added to a sticky status byte. After every sector the sector number steps forward, and at the end of a track it rolls over into the next head. When the operation ends, either normally or on an error, the engine raises a one-cycle completion pulse and drops its busy, transfer-in-progress and data-valid state. The drive's present cylinder arrives as a plain input. The storage behind the media request lies outside this block.

Top module: `dsk_xfer_engine`

## Requirements
- R1: Operation codes on `op`: read 0, write 1, check 2, address skip 3, read address 4, write address 5. In read and address skip, the engine stops without error at a sector start when the channel command is clear. Otherwise it asks the media for the sector and returns its words in buffer order on `dch_ibuf`. A `dch_flag` pulse comes with each word only when the command was set and the transfer is in progress. Each word served clears the command.
- R2: At a sector start, if the drive cylinder differs from the requested one or the sector is 23 or more, the operation stops with status 8'h11 (address error bit 4 plus error bit 0). This check comes before the head check.
- R3: At a sector start, a head of 20 or more stops the operation with status 8'h21 (end-of-cylinder bit 5 plus error bit 0).
- R4: Every sector transferred advances the sector number by one. On reaching 23 it returns to 0 and the head advances by one. `cur_head` and `cur_sec` show the result.
- R5: A write or write address to a protected drive stops at the sector start with status 8'h09 (protect bit 3 plus error bit 0). No media write is requested.
- R6: In a write, each stored word is the last channel output word if data-valid is set, and zero otherwise. Data-valid clears after each stored word. The full buffer goes to the media with the sector's head and sector. The operation stops without error at a sector start when both the command and data-valid are clear.
- R7: Check mode reads sectors without the data channel. It decrements the 9-bit count at each sector end and finishes when the count reaches zero.
- R8: Read address returns two words. The first is the drive cylinder. The second is the head in bits 12:8 and the sector in bits 4:0. After the second word the sector steps and returns to 0 at 23, with no change to the head.
- R9: Setting the channel command while the engine is busy and no transfer is in progress adds status 8'h03 (data error bit 1 plus error bit 0).
- R10: On completion the engine pulses `cch_flag` for one cycle, with `busy` low in the same cycle, and clears the transfer and data-valid state.
- R11: Within a sector, consecutive word steps are `pace`+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 3 | Operation code |
| drv_cyl | input | 8 | Cylinder the drive is positioned on |
| req_cyl | input | 8 | Requested cylinder |
| req_head | input | 5 | Requested head |
| req_sec | input | 5 | Requested sector |
| chk_count | input | 9 | Sector count for check mode |
| wr_protect | input | 1 | Drive is write protected |
| pace | input | PACE_W | Idle cycles between word steps |
| dch_stc | input | 1 | Set the channel command |
| dch_clc | input | 1 | Clear command and transfer-in-progress |
| dch_wr | input | 1 | Channel output word strobe |
| dch_obuf | input | 16 | Channel output word |
| dch_ibuf | output | 16 | Word returned to the channel |
| dch_flag | output | 1 | Word handed over |
| buf_addr | output | log2(WORDS) | Sector buffer address |
| buf_we | output | 1 | Sector buffer write strobe |
| buf_wdata | output | 16 | Sector buffer write data |
| buf_rdata | input | 16 | Sector buffer read data (combinational) |
| media_rd_req | output | 1 | Load buffer from media, held until ack |
| media_wr_req | output | 1 | Store buffer to media, held until ack |
| media_head | output | 5 | Head of the media request |
| media_sec | output | 5 | Sector of the media request |
| media_ack | input | 1 | Media request done |
| busy | output | 1 | Operation in progress |
| cch_flag | output | 1 | Completion pulse |
| status | output | 8 | Sticky status bits |
| cur_head | output | 5 | Current head |
| cur_sec | output | 5 | Current sector |

## Verification
A check-mode sweep covers all 32 sector codes against heads on both sides of the limit, including 19, 20 and 31. It separates the address-error path from the end-of-cylinder path and from the normal advance, and it confirms that the address fault wins when both apply. Multi-sector check runs cross the track end and then run into the head limit. A channel read compares its words with a per-address pattern and measures the spacing of the flags. Full and partial writes separate stored data from zero fill. Read address, protection and overrun are each run on their own, so that each fault code appears alone in the status.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_CHECK = 3'd2,
    OP_SKIP  = 3'd3,
    OP_RADDR = 3'd4,
    OP_WADDR = 3'd5
  } dxe_op_e;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_MRD, S_RDWORD, S_MWR} dxe_state_e;

  localparam logic [7:0] STS_ERR = 8'h01;
  localparam logic [7:0] STS_DTE = 8'h02;
  localparam logic [7:0] STS_FLG = 8'h08;
  localparam logic [7:0] STS_AER = 8'h10;
  localparam logic [7:0] STS_EOC = 8'h20;

  // Next {head, sector}: sector steps, rolls to 0 at nsec, head carries if asked.
  function automatic logic [9:0] step_addr(input logic [4:0] head, input logic [4:0] sec,
                                           input logic [4:0] nsec, input logic carry);
    logic [5:0] s1;
    s1 = {1'b0, sec} + 6'd1;
    if (s1 >= {1'b0, nsec}) return {head + {4'd0, carry}, 5'd0};
    return {head, s1[4:0]};
  endfunction

  function automatic logic [15:0] pack_hs(input logic [4:0] head, input logic [4:0] sec);
    return {3'b000, head, 3'b000, sec};
  endfunction
endpackage

// File: rtl/dxe_pacer.sv
module dxe_pacer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] interval,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= interval;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_PACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arm && (interval != '0) |=> !expire); // R11
endmodule

// File: rtl/dxe_addr_ctl.sv
module dxe_addr_ctl #(
  parameter int NSEC  = 23,
  parameter int NHEAD = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [4:0] ld_head,
  input  logic [4:0] ld_sec,
  input  logic       step,
  input  logic       carry,
  input  logic       cyl_ok,
  output logic [4:0] head,
  output logic [4:0] sec,
  output logic       aer,
  output logic       eoc
);
  import dxe_pkg::*;

  localparam logic [4:0] NSEC_V  = 5'(NSEC);
  localparam logic [4:0] NHEAD_V = 5'(NHEAD);

  logic [4:0] head_q, sec_q;
  logic [9:0] nxt;

  assign nxt  = step_addr(head_q, sec_q, NSEC_V, carry);
  assign head = head_q;
  assign sec  = sec_q;
  assign aer  = !cyl_ok || (sec_q >= NSEC_V);
  assign eoc  = head_q >= NHEAD_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      sec_q  <= '0;
    end else if (load) begin
      head_q <= ld_head;
      sec_q  <= ld_sec;
    end else if (step) begin
      {head_q, sec_q} <= nxt;
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && (sec_q == NSEC_V - 5'd1) |=> sec_q == 5'd0); // R4
  AST_HEAD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && carry && (sec_q == NSEC_V - 5'd1) |=> head_q == $past(head_q) + 5'd1); // R4
  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !carry |=> head_q == $past(head_q)); // R8
endmodule

// File: rtl/dsk_xfer_engine.sv
module dsk_xfer_engine #(
  parameter int WORDS  = 128,
  parameter int NSEC   = 23,
  parameter int NHEAD  = 20,
  parameter int PACE_W = 8,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [7:0]        drv_cyl,
  input  logic [7:0]        req_cyl,
  input  logic [4:0]        req_head,
  input  logic [4:0]        req_sec,
  input  logic [8:0]        chk_count,
  input  logic              wr_protect,
  input  logic [PACE_W-1:0] pace,
  input  logic              dch_stc,
  input  logic              dch_clc,
  input  logic              dch_wr,
  input  logic [15:0]       dch_obuf,
  output logic [15:0]       dch_ibuf,
  output logic              dch_flag,
  output logic [PTR_W-1:0]  buf_addr,
  output logic              buf_we,
  output logic [15:0]       buf_wdata,
  input  logic [15:0]       buf_rdata,
  output logic              media_rd_req,
  output logic              media_wr_req,
  output logic [4:0]        media_head,
  output logic [4:0]        media_sec,
  input  logic              media_ack,
  output logic              busy,
  output logic              cch_flag,
  output logic [7:0]        status,
  output logic [4:0]        cur_head,
  output logic [4:0]        cur_sec
);
  import dxe_pkg::*;

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(WORDS - 1);

  dxe_state_e       state_q;
  dxe_op_e          op_q;
  logic [PTR_W-1:0] ptr_q;
  logic [8:0]       cnt_q;
  logic [7:0]       rcyl_q, status_q;
  logic [15:0]      ibuf_q, obuf_q;
  logic [4:0]       mhead_q, msec_q;
  logic             cmd_q, xfer_q, wval_q, busy_q, wp_q, flag_q, done_q;

  // named internal events
  logic tick, at_start, last, is_rdl, is_wr, is_ra;
  logic ev_accept, ev_finish, ev_cnt_end, ev_rd_begin, ev_rd_word, ev_wr_store, ev_ra_word;
  logic ev_serve, ev_adv, ev_arm, ev_overrun;
  logic [7:0] err_bits;
  logic pace_exp, aer, eoc;

  dxe_pacer #(.W(PACE_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .arm(ev_arm), .interval(pace), .expire(pace_exp)
  );

  dxe_addr_ctl #(.NSEC(NSEC), .NHEAD(NHEAD)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .ld_head(req_head), .ld_sec(req_sec),
    .step(ev_adv), .carry(!is_ra), .cyl_ok(drv_cyl == rcyl_q),
    .head(cur_head), .sec(cur_sec), .aer(aer), .eoc(eoc)
  );

  always_comb begin
    is_rdl   = (op_q == OP_READ) || (op_q == OP_CHECK) || (op_q == OP_SKIP);
    is_wr    = (op_q == OP_WRITE) || (op_q == OP_WADDR);
    is_ra    = (op_q == OP_RADDR);
    tick     = (state_q == S_WAIT) && pace_exp;
    at_start = (ptr_q == '0);
    last     = (ptr_q == LAST_PTR);
    ev_accept   = (state_q == S_IDLE) && start;
    ev_finish   = 1'b0;
    ev_rd_begin = 1'b0;
    ev_rd_word  = 1'b0;
    ev_wr_store = 1'b0;
    ev_ra_word  = 1'b0;
    err_bits    = 8'h00;
    if (tick) begin
      if (!is_rdl && !is_wr && !is_ra) ev_finish = 1'b1;
      else if (is_ra) begin
        if (!cmd_q || (ptr_q >= PTR_W'(2))) ev_finish = 1'b1;
        else ev_ra_word = 1'b1;
      end else if (at_start) begin
        if ((is_rdl && (op_q != OP_CHECK) && !cmd_q) || (is_wr && !cmd_q && !wval_q))
          ev_finish = 1'b1;
        else if (is_wr && wp_q) begin
          ev_finish = 1'b1;
          err_bits  = STS_FLG | STS_ERR;
        end else if (aer) begin
          ev_finish = 1'b1;
          err_bits  = STS_AER | STS_ERR;
        end else if (eoc) begin
          ev_finish = 1'b1;
          err_bits  = STS_EOC | STS_ERR;
        end else if (is_rdl) ev_rd_begin = 1'b1;
        else ev_wr_store = 1'b1;
      end else if (is_rdl) ev_rd_word = 1'b1;
      else ev_wr_store = 1'b1;
    end
    if (state_q == S_RDWORD) ev_rd_word = 1'b1;
    ev_cnt_end = ev_rd_word && last && (op_q == OP_CHECK) && (cnt_q == 9'd1);
    if (ev_cnt_end) ev_finish = 1'b1;
    ev_serve   = ev_rd_word || ev_wr_store || ev_ra_word;
    ev_adv     = ev_rd_begin || (ev_wr_store && last) || (ev_ra_word && (ptr_q == PTR_W'(1)));
    ev_arm     = ev_accept || (ev_serve && !ev_finish && !(ev_wr_store && last)) ||
                 ((state_q == S_MWR) && media_ack);
    ev_overrun = dch_stc && busy_q && !xfer_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_READ;
      ptr_q    <= '0;
      cnt_q    <= '0;
      rcyl_q   <= '0;
      status_q <= '0;
      ibuf_q   <= '0;
      obuf_q   <= '0;
      mhead_q  <= '0;
      msec_q   <= '0;
      cmd_q    <= 1'b0;
      xfer_q   <= 1'b0;
      wval_q   <= 1'b0;
      busy_q   <= 1'b0;
      wp_q     <= 1'b0;
      flag_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      flag_q <= ev_serve && !ev_cnt_end && cmd_q && xfer_q;
      done_q <= ev_finish;
      // sequencing
      unique case (state_q)
        S_IDLE:   if (ev_accept) state_q <= S_WAIT;
        S_WAIT: begin
          if (ev_finish) state_q <= S_IDLE;
          else if (ev_rd_begin) state_q <= S_MRD;
          else if (ev_wr_store && last) state_q <= S_MWR;
        end
        S_MRD:    if (media_ack) state_q <= S_RDWORD;
        S_RDWORD: state_q <= ev_finish ? S_IDLE : S_WAIT;
        S_MWR:    if (media_ack) state_q <= S_WAIT;
        default:  state_q <= S_IDLE;
      endcase
      if (ev_accept) begin
        op_q     <= dxe_op_e'(op);
        rcyl_q   <= req_cyl;
        cnt_q    <= chk_count;
        wp_q     <= wr_protect;
        ptr_q    <= '0;
        status_q <= 8'h00;
        busy_q   <= 1'b1;
        xfer_q   <= 1'b1;
      end else begin
        status_q <= status_q | err_bits | (ev_overrun ? (STS_DTE | STS_ERR) : 8'h00);
      end
      if (ev_serve) ptr_q <= (last && !is_ra) ? '0 : ptr_q + 1'b1;
      if (ev_rd_word) ibuf_q <= buf_rdata;
      if (ev_ra_word) ibuf_q <= at_start ? {8'h00, drv_cyl} : pack_hs(cur_head, cur_sec);
      if (ev_rd_word && last && (op_q == OP_CHECK)) cnt_q <= cnt_q - 9'd1;
      if (ev_adv && !is_ra) begin
        mhead_q <= cur_head;
        msec_q  <= cur_sec;
      end
      // channel handshake
      if (ev_serve) cmd_q <= 1'b0;
      if (dch_stc) cmd_q <= 1'b1;
      if (dch_clc) begin
        cmd_q  <= 1'b0;
        xfer_q <= 1'b0;
      end
      if (dch_wr) obuf_q <= dch_obuf;
      if (ev_wr_store) wval_q <= 1'b0;
      if (dch_wr && (!busy_q || xfer_q)) wval_q <= 1'b1;
      if (ev_finish) begin
        busy_q <= 1'b0;
        xfer_q <= 1'b0;
        wval_q <= 1'b0;
      end
    end
  end

  assign dch_ibuf     = ibuf_q;
  assign dch_flag     = flag_q;
  assign buf_addr     = ptr_q;
  assign buf_we       = ev_wr_store;
  assign buf_wdata    = wval_q ? obuf_q : 16'h0000;
  assign media_rd_req = (state_q == S_MRD);
  assign media_wr_req = (state_q == S_MWR);
  assign media_head   = mhead_q;
  assign media_sec    = msec_q;
  assign busy         = busy_q;
  assign cch_flag     = done_q;
  assign status       = status_q;

  AST_FLAG_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    dch_flag |-> $past(xfer_q) && $past(cmd_q)); // R1
  AST_MEDIA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({media_rd_req, media_wr_req})); // R1
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[5:1] != 4'h0 && status_q[5:1] != 5'h00) |-> status_q[0]); // R2
  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    media_wr_req |-> !wp_q); // R5
  AST_WVAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we && !dch_wr |=> !wval_q); // R6
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    dch_stc && busy && !xfer_q |=> status_q[1] && status_q[0]); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cch_flag |-> !busy_q && !xfer_q && !wval_q); // R10
endmodule

// File: tb/dsk_xfer_engine_tb.sv
`timescale 1ns/1ps
module dsk_xfer_engine_tb;
  localparam int WORDS = 4;
  localparam int NSEC  = 23;
  localparam int NHEAD = 20;
  localparam int WDOG  = 150000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, wr_protect = 0, dch_stc = 0, dch_clc = 0, dch_wr = 0, media_ack = 0;
  logic [2:0]  op = 0;
  logic [7:0]  drv_cyl = 8'd37, req_cyl = 8'd37, status;
  logic [4:0]  req_head = 0, req_sec = 0, media_head, media_sec, cur_head, cur_sec;
  logic [8:0]  chk_count = 0;
  logic [7:0]  pace = 8'd1;
  logic [15:0] dch_obuf = 0, dch_ibuf, buf_wdata, buf_rdata;
  logic [1:0]  buf_addr;
  logic        dch_flag, buf_we, media_rd_req, media_wr_req, busy, cch_flag;

  logic [15:0] bmem [0:WORDS-1];
  logic [15:0] wsnap [0:WORDS-1];
  logic [4:0]  wr_h, wr_s;
  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0, wr_cnt = 0;
  bit  ended = 0;

  always #4 clk = ~clk;

  dsk_xfer_engine #(.WORDS(WORDS), .NSEC(NSEC), .NHEAD(NHEAD), .PACE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .drv_cyl(drv_cyl), .req_cyl(req_cyl),
    .req_head(req_head), .req_sec(req_sec), .chk_count(chk_count), .wr_protect(wr_protect),
    .pace(pace), .dch_stc(dch_stc), .dch_clc(dch_clc), .dch_wr(dch_wr), .dch_obuf(dch_obuf),
    .dch_ibuf(dch_ibuf), .dch_flag(dch_flag), .buf_addr(buf_addr), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .media_rd_req(media_rd_req),
    .media_wr_req(media_wr_req), .media_head(media_head), .media_sec(media_sec),
    .media_ack(media_ack), .busy(busy), .cch_flag(cch_flag), .status(status),
    .cur_head(cur_head), .cur_sec(cur_sec)
  );

  function automatic logic [15:0] pat(input logic [4:0] h, input logic [4:0] s, input int i);
    return {h, s, 6'(i)};
  endfunction

  assign buf_rdata = bmem[buf_addr];

  // sector buffer and media model
  always @(negedge clk) begin
    if (buf_we) bmem[buf_addr] = buf_wdata;
    if (media_ack) media_ack = 1'b0;
    else if (media_rd_req) begin
      for (int i = 0; i < WORDS; i++) bmem[i] = pat(media_head, media_sec, i);
      rd_cnt++;
      media_ack = 1'b1;
    end else if (media_wr_req) begin
      for (int i = 0; i < WORDS; i++) wsnap[i] = bmem[i];
      wr_h = media_head;
      wr_s = media_sec;
      wr_cnt++;
      media_ack = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !ended) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clc();
    @(negedge clk); dch_clc = 1; @(negedge clk); dch_clc = 0;
  endtask
  task automatic stc();
    @(negedge clk); dch_stc = 1; @(negedge clk); dch_stc = 0;
  endtask
  task automatic stc_now();
    dch_stc = 1; @(negedge clk); dch_stc = 0;
  endtask
  task automatic put_now(input logic [15:0] d);
    dch_obuf = d; dch_wr = 1; dch_stc = 1; @(negedge clk); dch_wr = 0; dch_stc = 0;
  endtask

  task automatic go(input logic [2:0] o, input logic [7:0] rc, input logic [4:0] h,
                    input logic [4:0] s, input logic [8:0] c, input logic wp);
    @(negedge clk);
    op = o; req_cyl = rc; req_head = h; req_sec = s; chk_count = c; wr_protect = wp; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!cch_flag && n < 5000) begin @(negedge clk); n++; end
    chk({req, " completion pulse with busy low"}, {30'd0, cch_flag, busy}, 32'b10);
  endtask

  task automatic wait_flag(input string req, output int at);
    int n = 0;
    @(negedge clk);
    while (!dch_flag && n < 2000) begin @(negedge clk); n++; end
    at = cyc;
    chk({req, " word flag"}, {31'd0, dch_flag}, 32'd1);
  endtask

  initial begin
    int t [0:WORDS-1];
    int r0;
    logic [4:0] h, es, eh;
    logic [7:0] est;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R10)
    chk("R10 reset busy", busy, 0);
    chk("R10 reset status", status, 0);
    chk("R10 reset flags", {dch_flag, cch_flag}, 0);

    // sweep sector/head codes in check mode (R2 R3 R4 R7)
    pace = 8'd1;
    for (int s = 0; s < 32; s++) begin
      for (int hi = 0; hi < 5; hi++) begin
        case (hi)
          0: h = 5'd0; 1: h = 5'd18; 2: h = 5'd19; 3: h = 5'd20; default: h = 5'd31;
        endcase
        r0 = rd_cnt;
        go(3'd2, 8'd37, h, 5'(s), 9'd1, 1'b0);
        wait_done("R7 sweep");
        es = 5'(s); eh = h; est = 8'h00;
        if (s >= NSEC) est = 8'h11;
        else if (h >= NHEAD) est = 8'h21;
        else begin
          if (s + 1 == NSEC) begin es = 0; eh = h + 5'd1; end
          else es = 5'(s + 1);
        end
        chk("R2/R3 sweep status", status, est);
        chk("R4 sweep sector", cur_sec, es);
        chk("R4 sweep head", cur_head, eh);
        chk("R7 sweep media reads", rd_cnt - r0, (est == 0) ? 1 : 0);
      end
    end

    // cylinder mismatch (R2)
    go(3'd2, 8'd38, 5'd1, 5'd1, 9'd1, 1'b0);
    wait_done("R2 cylinder");
    chk("R2 cylinder mismatch status", status, 8'h11);

    // multi-sector check across track end (R7 R4)
    r0 = rd_cnt;
    go(3'd2, 8'd37, 5'd3, 5'd21, 9'd3, 1'b0);
    wait_done("R7 count");
    chk("R7 three sectors read", rd_cnt - r0, 3);
    chk("R7 status", status, 8'h00);
    chk("R4 head carry", {cur_head, cur_sec}, {5'd4, 5'd1});
    go(3'd2, 8'd37, 5'd19, 5'd22, 9'd2, 1'b0);
    wait_done("R3 carry into limit");
    chk("R3 head limit after carry", status, 8'h21);
    chk("R4 position at limit", {cur_head, cur_sec}, {5'd20, 5'd0});

    // channel read with pacing (R1 R11)
    pace = 8'd5;
    clc(); stc();
    go(3'd0, 8'd37, 5'd2, 5'd7, 9'd0, 1'b0);
    for (int i = 0; i < WORDS; i++) begin
      wait_flag("R1 read", t[i]);
      chk("R1 read data", dch_ibuf, pat(5'd2, 5'd7, i));
      if (i < WORDS - 1) stc_now();
    end
    for (int i = 2; i < WORDS; i++) chk("R11 word spacing", t[i] - t[i-1], 6);
    wait_done("R1 read");
    chk("R1 read status", status, 8'h00);
    chk("R4 read advance", {cur_head, cur_sec}, {5'd2, 5'd8});

    // full write (R6)
    clc();
    @(negedge clk); put_now(16'hA000);
    go(3'd1, 8'd37, 5'd1, 5'd4, 9'd0, 1'b0);
    r0 = wr_cnt;
    for (int i = 1; i < WORDS; i++) begin
      wait_flag("R6 write", t[i]);
      put_now(16'hA000 + 16'(i));
    end
    wait_done("R6 write");
    chk("R6 one media write", wr_cnt - r0, 1);
    for (int i = 0; i < WORDS; i++) chk("R6 stored word", wsnap[i], 16'hA000 + 16'(i));
    chk("R6 media address", {wr_h, wr_s}, {5'd1, 5'd4});
    chk("R6 write status", status, 8'h00);
    chk("R4 write advance", cur_sec, 5'd5);

    // partial write, zero fill (R6)
    clc();
    @(negedge clk); put_now(16'h1234);
    go(3'd5, 8'd37, 5'd1, 5'd5, 9'd0, 1'b0);
    wait_flag("R6 fill", t[0]);
    put_now(16'h5678);
    wait_done("R6 fill");
    chk("R6 fill word0", wsnap[0], 16'h1234);
    chk("R6 fill word1", wsnap[1], 16'h5678);
    chk("R6 fill word2 zero", wsnap[2], 16'h0000);
    chk("R6 fill word3 zero", wsnap[3], 16'h0000);

    // write protect (R5)
    clc();
    @(negedge clk); put_now(16'hBEEF);
    r0 = wr_cnt;
    go(3'd1, 8'd37, 5'd0, 5'd0, 9'd0, 1'b1);
    wait_done("R5 protect");
    chk("R5 protect status", status, 8'h09);
    chk("R5 no media write", wr_cnt - r0, 0);

    // read address (R8)
    pace = 8'd3;
    clc(); stc();
    go(3'd4, 8'd37, 5'd5, 5'd22, 9'd0, 1'b0);
    wait_flag("R8 first", t[0]);
    chk("R8 cylinder word", dch_ibuf, 16'd37);
    stc_now();
    wait_flag("R8 second", t[1]);
    chk("R8 head/sector word", dch_ibuf, 16'h0516);
    wait_done("R8 read address");
    chk("R8 sector wraps, head kept", {cur_head, cur_sec}, {5'd5, 5'd0});
    chk("R8 status", status, 8'h00);

    // overrun (R9)
    clc();
    go(3'd2, 8'd37, 5'd0, 5'd0, 9'd2, 1'b0);
    clc(); stc();
    wait_done("R9 overrun");
    chk("R9 overrun status", status, 8'h03);

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule